// File: doc/BRIEF.md
# General-Call Software Reset Detector

This block sits behind a shared two-wire serial bus front end. That front end does the bit-level work and hands over bus events at byte level: a START or repeated START, a STOP, and each received byte. The detector looks for one exact sequence. The sequence is the general-call address written as 00h, then the command byte 06h, then STOP. The detector decides whether each byte is acknowledged. When the full sequence completes, it emits a single-cycle pulse that returns the attached device's registers to their power-up values.

Received bytes arrive on a valid/ready stream. The acknowledge decision for each byte leaves on a second valid/ready stream.

- A byte is taken on any cycle where `rx_valid` and `rx_ready` are both high.
- The decision appears on `ack_valid` and `ack_ok` on the next cycle.
- The decision is held until `ack_ready` is seen high.
- While a decision is held and `ack_ready` is low, `rx_ready` is low, so back-pressure on the decision stream stalls the byte stream.

START and STOP are plain single-cycle strobes. They take priority over a byte offered in the same cycle, and STOP wins over START. Only the general-call reset command is ever acknowledged. Every other byte gets a NACK (`ack_ok` low).

Top module: `gcrst_detector`

## Requirements
- R1: After reset, `srst_pulse` is 0, `ack_valid` is 0 and `rx_ready` is 1.
- R2: The first byte after a START is acknowledged (`ack_ok`=1) only when it equals 00h. Every other first byte gets a NACK.
- R3: A first byte of 01h (general-call address with the read bit set) gets a NACK, and a following 06h also gets a NACK.
- R4: After an acknowledged 00h, the next byte is acknowledged only if it equals 06h. Any other value gets a NACK, and a later STOP produces no pulse.
- R5: Any byte after an acknowledged 06h gets a NACK, and the following STOP produces no pulse.
- R6: A STOP that directly follows an acknowledged 06h raises `srst_pulse` for exactly one cycle. The pulse appears in the cycle after the STOP strobe. The detector then returns to idle.
- R7: A START that arrives after an acknowledged 06h, instead of a STOP, cancels the reset. No pulse follows, and the next byte is evaluated as an address.
- R8: Bytes received with no START since reset or since the last STOP get a NACK.
- R9: The decision for a byte accepted at edge k is valid after edge k and holds, unchanged, until it is taken with `ack_ready`. While it is held and not taken, `rx_ready` is 0.
- R10: Every START returns the detector to its initial state. For example, 00h, START, 06h gives a NACK for the 06h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | One-cycle strobe: START or repeated START seen |
| ev_stop | input | 1 | One-cycle strobe: STOP seen |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Detector can take a byte |
| rx_data | input | BYTE_W | Received byte |
| ack_valid | output | 1 | Acknowledge decision available |
| ack_ready | input | 1 | Front end takes the decision |
| ack_ok | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| srst_pulse | output | 1 | One-cycle software reset request |

## Verification
On every cycle, the bound checker enforces the following rules:
- The reset pulse lasts one cycle and follows a STOP strobe.
- Decisions follow accepted bytes and hold steady under back-pressure, and `rx_ready` is low during that hold.
- Bytes that arrive with no START since the last STOP always get a NACK.

Which byte values get an ACK, and whether a given event history leads to a reset, depend on the whole sequence. Only the bench shows these. It sweeps all 256 values as the address byte and all 256 values as the command byte, and adds directed sequences with extra bytes, repeated STARTs and stalled decisions.

// File: rtl/gcrst_pkg.sv
package gcrst_pkg;
  typedef enum logic [1:0] {
    GC_HUNT  = 2'd0,
    GC_ADDR  = 2'd1,
    GC_CMD   = 2'd2,
    GC_ARMED = 2'd3
  } gc_state_e;
endpackage

// File: rtl/gcrst_fsm.sv
module gcrst_fsm
  import gcrst_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] GC_WORD  = '0,
  parameter logic [BYTE_W-1:0] RST_CODE = BYTE_W'(6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  output logic              byte_ok,
  output logic              fire
);
  gc_state_e state_q, state_d;

  // Acknowledge decision for the byte currently offered
  always_comb begin
    unique case (state_q)
      GC_ADDR: byte_ok = (data == GC_WORD);
      GC_CMD:  byte_ok = (data == RST_CODE);
      default: byte_ok = 1'b0;
    endcase
  end

  // Reset request: STOP straight after an acknowledged command
  assign fire = ev_stop && (state_q == GC_ARMED);

  always_comb begin
    state_d = state_q;
    if (ev_stop) begin
      state_d = GC_HUNT;
    end else if (ev_start) begin
      state_d = GC_ADDR;
    end else if (take) begin
      unique case (state_q)
        GC_ADDR: state_d = byte_ok ? GC_CMD   : GC_HUNT;
        GC_CMD:  state_d = byte_ok ? GC_ARMED : GC_HUNT;
        default: state_d = GC_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= GC_HUNT;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/gcrst_ackbuf.sv
module gcrst_ackbuf (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_ok,
  output logic out_valid,
  input  logic out_ready,
  output logic out_ok
);
  logic full_q, ok_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_ok    = ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      ok_q   <= in_ok;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gcrst_pulse.sv
module gcrst_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= req;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/gcrst_detector.sv
module gcrst_detector #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] GC_WORD  = '0,
  parameter logic [BYTE_W-1:0] RST_CODE = BYTE_W'(6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic              ack_ok,
  output logic              srst_pulse
);
  logic take, byte_ok, fire;

  // A byte offered alongside a START/STOP strobe is dropped: events win
  assign take = rx_valid && rx_ready && !ev_start && !ev_stop;

  gcrst_fsm #(
    .BYTE_W(BYTE_W), .GC_WORD(GC_WORD), .RST_CODE(RST_CODE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .take(take), .data(rx_data), .byte_ok(byte_ok), .fire(fire)
  );

  gcrst_ackbuf u_ack (
    .clk(clk), .rst_n(rst_n), .in_valid(take), .in_ready(rx_ready),
    .in_ok(byte_ok), .out_valid(ack_valid), .out_ready(ack_ready),
    .out_ok(ack_ok)
  );

  gcrst_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .req(fire), .pulse(srst_pulse)
  );
endmodule

// File: rtl/gcrst_chk.sv
module gcrst_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_start,
  input logic ev_stop,
  input logic rx_valid,
  input logic rx_ready,
  input logic ack_valid,
  input logic ack_ready,
  input logic ack_ok,
  input logic srst_pulse
);
  logic in_frame_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        in_frame_q <= 1'b0;
    else if (ev_stop)  in_frame_q <= 1'b0;
    else if (ev_start) in_frame_q <= 1'b1;
  end

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> !srst_pulse);
  a_r6_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |-> $past(ev_stop));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_ok)));
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |-> !rx_ready);
  a_r9_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !ev_start && !ev_stop) |=> ack_valid);
  a_r8_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !ev_start && !ev_stop && !in_frame_q) |=> !ack_ok);
endmodule

bind gcrst_detector gcrst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .ack_valid(ack_valid),
  .ack_ready(ack_ready), .ack_ok(ack_ok), .srst_pulse(srst_pulse)
);

// File: tb/tb_gcrst_detector.sv
module tb_gcrst_detector;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, ev_start, ev_stop, rx_valid, ack_ready;
  logic [7:0] rx_data;
  logic rx_ready, ack_valid, ack_ok, srst_pulse;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gcrst_detector dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_ok(ack_ok),
    .srst_pulse(srst_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_start();
    ev_start = 1'b1; step(); ev_start = 1'b0;
  endtask

  // STOP, then check the pulse in the following cycle and its end after that
  task automatic do_stop(input string req, input bit exp_pulse);
    ev_stop = 1'b1; step(); ev_stop = 1'b0;
    check(req, int'(srst_pulse), int'(exp_pulse));
    step();
    check(req, int'(srst_pulse), 0);
  endtask

  task automatic send(input string req, input logic [7:0] b, input bit exp_ok);
    rx_data = b; rx_valid = 1'b1; step(); rx_valid = 1'b0;
    check(req, int'(ack_valid), 1);
    check(req, int'(ack_ok), int'(exp_ok));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_start = 0; ev_stop = 0; rx_valid = 0; ack_ready = 1;
    rx_data = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    check("R1", int'(srst_pulse), 0);
    check("R1", int'(ack_valid), 0);
    check("R1", int'(rx_ready), 1);

    // R8: bytes with no START
    send("R8", 8'h00, 0);
    send("R8", 8'h06, 0);
    do_stop("R8", 0);

    // R2 sweep over every address byte
    for (int b = 0; b < 256; b++) begin
      do_start();
      send("R2", 8'(b), b == 0);
      do_stop("R2", 0);
    end

    // R3: read-flavoured general call
    do_start(); send("R3", 8'h01, 0); send("R3", 8'h06, 0); do_stop("R3", 0);

    // R4/R6 sweep over every command byte
    for (int b = 0; b < 256; b++) begin
      do_start();
      send("R4", 8'h00, 1);
      send("R4", 8'(b), b == 6);
      do_stop(b == 6 ? "R6" : "R4", b == 6);
    end

    // R6: idle after reset pulse, byte without START NACKed
    do_start(); send("R6", 8'h00, 1); send("R6", 8'h06, 1); do_stop("R6", 1);
    send("R6", 8'h00, 0);

    // R5: extra byte aborts
    do_start(); send("R5", 8'h00, 1); send("R5", 8'h06, 1);
    send("R5", 8'h06, 0); do_stop("R5", 0);

    // R7: repeated START cancels, next byte is an address
    do_start(); send("R7", 8'h00, 1); send("R7", 8'h06, 1);
    do_start(); check("R7", int'(srst_pulse), 0);
    send("R7", 8'h00, 1); send("R7", 8'h06, 1); do_stop("R7", 1);

    // R10: START mid-sequence restarts evaluation
    do_start(); send("R10", 8'h00, 1);
    do_start(); send("R10", 8'h06, 0); do_stop("R10", 0);

    // R9: back-pressure on the decision stream
    do_start();
    ack_ready = 1'b0;
    rx_data = 8'h00; rx_valid = 1'b1; step(); rx_valid = 1'b0;
    check("R9", int'(ack_valid), 1);
    check("R9", int'(ack_ok), 1);
    check("R9", int'(rx_ready), 0);
    step();
    check("R9", int'(ack_valid), 1);
    check("R9", int'(rx_ready), 0);
    rx_data = 8'h05; rx_valid = 1'b1; step();
    check("R9", int'(ack_valid), 1);
    check("R9", int'(ack_ok), 1);
    rx_data = 8'h06; ack_ready = 1'b1; step(); rx_valid = 1'b0;
    check("R9", int'(ack_valid), 1);
    check("R9", int'(ack_ok), 1);
    step();
    check("R9", int'(ack_valid), 0);
    do_stop("R9", 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule